// File: doc/BRIEF.md
# Crystal Oscillator Fault Monitor

This block watches a slow external crystal clock from the system-clock side. The crystal input is synchronized and reduced to one tick per rising edge. A retriggerable timeout, restarted by every tick, raises an internal dead-crystal condition when no tick arrives within a window of system-clock cycles. A sticky crystal fault flag is set by hardware whenever that condition exists. Software may request a clear of the flag, but the request only takes effect once a counter of consecutive fault-free ticks has reached its threshold. A read on the cycle after the request therefore shows whether the clear was accepted.

A second sticky flag, the global oscillator fault, follows the crystal flag upward and is only ever cleared by software. While the global flag is set and the crystal runs in low-frequency mode, the auxiliary clock output is switched to an internal backup reference. A handshaking switch moves between the two sources without runt pulses. When the crystal has stopped, the crystal side of the switch is released directly, so that the backup can take over.

Top module: `xtal_fault_mon`

## Requirements
- R1: After reset, the crystal fault flag, the global fault flag and the backup selection output all read 1.
- R2: When crystal rising edges stop, the crystal fault flag is set once the timeout window of TIMEOUT_CYC system cycles has passed since the last edge. It is not set while edges arrive more often than the window.
- R3: In low-frequency mode (hf_mode = 0), a clear request (clr_xfault = 1 for one cycle) is ignored while fewer than LF_TICKS fault-free ticks have been counted. The flag still reads 1 on the next cycle.
- R4: In low-frequency mode, a clear request made after at least LF_TICKS fault-free ticks clears the crystal fault flag on the next cycle.
- R5: In high-frequency or bypass mode (hf_mode = 1), the required fault-free count is HF_TICKS instead of LF_TICKS.
- R6: A dead-crystal interval resets the tick count. Ticks counted before the interval do not count toward the threshold afterwards.
- R7: Whenever the crystal fault flag is 1, the global fault flag is 1. Hardware never clears the global flag.
- R8: The global flag is cleared only by clr_gfault. That request is ignored while the crystal fault flag is 1.
- R9: aux_backup equals 1 exactly when the global flag is set and hf_mode = 0. aux_clk then follows ref_clk; otherwise aux_clk follows xtal_in.
- R10: The two clock sources are never enabled onto aux_clk at the same time, and aux_clk carries no pulse shorter than the shorter half period of its two sources.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xtal_in | input | 1 | Crystal clock, asynchronous to clk |
| ref_clk | input | 1 | Internal backup reference clock |
| hf_mode | input | 1 | 0 = low-frequency crystal, 1 = high-frequency or bypass |
| clr_xfault | input | 1 | Write-one-to-clear request for the crystal fault flag |
| clr_gfault | input | 1 | Write-one-to-clear request for the global fault flag |
| xfault | output | 1 | Sticky crystal fault flag |
| gfault | output | 1 | Sticky global oscillator fault flag |
| aux_backup | output | 1 | 1 while the auxiliary clock is routed from the backup |
| aux_clk | output | 1 | Auxiliary clock output |

## Verification
The bench issues clear requests both before and after the tick threshold in each mode. A design that compared against the wrong threshold, or that let a clear through unconditionally, would show the flag dropping too early. It also stops the crystal halfway through a run and then resumes it. A counter that was never reset by the dead interval would accept a clear that must be refused. It checks that the global flag survives the crystal flag clearing and that aux_clk follows the right source on both sides of each switch. A pulse-width monitor on aux_clk catches a switch that cuts a source mid-pulse.

// File: rtl/xfm_pkg.sv
package xfm_pkg;

    typedef enum logic {
        XFM_LOW_FREQ  = 1'b0,
        XFM_HIGH_FREQ = 1'b1
    } xfm_mode_e;

    // Pick the fault-free tick threshold for the current mode
    function automatic int unsigned xfm_threshold(xfm_mode_e mode,
                                                  int unsigned lf_ticks,
                                                  int unsigned hf_ticks);
        return (mode == XFM_HIGH_FREQ) ? hf_ticks : lf_ticks;
    endfunction

endpackage

// File: rtl/xfm_sync_edge.sv
module xfm_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise
);
    // Chain of STAGES synchronizer flops plus one delay flop for edge detect
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign level = sh_q[STAGES-1];
    assign rise  = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/xfm_timeout.sv
module xfm_timeout #(
    parameter int WINDOW = 12500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic expired
);
    localparam int TW = $clog2(WINDOW + 1);
    localparam logic [TW-1:0] LIMIT = TW'(WINDOW);

    logic [TW-1:0] age_d, age_q;

    always_comb begin
        if (kick)                age_d = '0;
        else if (age_q == LIMIT) age_d = age_q;
        else                     age_d = age_q + 1'b1;
    end

    // Reset to the expired state: no crystal edge has been seen yet
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age_q <= LIMIT;
        else        age_q <= age_d;
    end

    assign expired = (age_q == LIMIT);
endmodule

// File: rtl/xfm_clk_switch.sv
module xfm_clk_switch (
    input  logic rst_n,
    input  logic sel_b,
    input  logic clk_a,
    input  logic kill_a,
    input  logic clk_b,
    output logic a_en,
    output logic b_en,
    output logic clk_out
);
    logic [1:0] a_d, a_q;
    logic [1:0] b_d, b_q;
    logic       rst_a_n;

    // A dead source cannot step its own handshake down, so release it directly
    assign rst_a_n = rst_n & ~kill_a;

    always_comb begin
        a_d = {a_q[0], ~sel_b & ~b_q[0] & ~b_q[1]};
        b_d = {b_q[0],  sel_b & ~a_q[0] & ~a_q[1]};
    end

    // Enables change on the falling edge of their own clock, while it is low
    always_ff @(negedge clk_a or negedge rst_a_n) begin
        if (!rst_a_n) a_q <= '0;
        else          a_q <= a_d;
    end

    always_ff @(negedge clk_b or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign a_en    = a_q[1];
    assign b_en    = b_q[1];
    assign clk_out = (clk_a & a_q[1]) | (clk_b & b_q[1]);
endmodule

// File: rtl/xtal_fault_mon.sv
module xtal_fault_mon
    import xfm_pkg::*;
#(
    parameter int TIMEOUT_CYC = 12500,
    parameter int LF_TICKS    = 8192,
    parameter int HF_TICKS    = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic xtal_in,
    input  logic ref_clk,
    input  logic hf_mode,
    input  logic clr_xfault,
    input  logic clr_gfault,
    output logic xfault,
    output logic gfault,
    output logic aux_backup,
    output logic aux_clk
);
    localparam int CW = $clog2(LF_TICKS + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(LF_TICKS);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          xflag;
        logic          gflag;
        logic          sel;
    } mon_state_t;

    mon_state_t st_d, st_q;

    logic      xtal_lvl, xtal_rise;
    logic      osc_dead;
    logic      run_ok;
    logic      x_en, b_en;
    xfm_mode_e mode;
    logic [CW-1:0] thresh;

    assign mode   = xfm_mode_e'(hf_mode);
    assign thresh = CW'(xfm_threshold(mode, LF_TICKS, HF_TICKS));

    xfm_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (xtal_in),
        .level    (xtal_lvl),
        .rise     (xtal_rise)
    );

    xfm_timeout #(.WINDOW(TIMEOUT_CYC)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .kick    (xtal_rise),
        .expired (osc_dead)
    );

    always_comb begin
        st_d = st_q;

        // Fault-free tick count, cleared by any dead interval, saturating
        if (osc_dead)
            st_d.cnt = '0;
        else if (xtal_rise && (st_q.cnt < CNT_MAX))
            st_d.cnt = st_q.cnt + 1'b1;

        run_ok = (st_q.cnt >= thresh) && !osc_dead;

        // Crystal flag: hardware set wins, clear only when gated open
        if (osc_dead)
            st_d.xflag = 1'b1;
        else if (clr_xfault && run_ok)
            st_d.xflag = 1'b0;

        // Global flag: follows the crystal flag up, software-only clear
        if (st_d.xflag)
            st_d.gflag = 1'b1;
        else if (clr_gfault)
            st_d.gflag = 1'b0;

        st_d.sel = st_d.gflag && (mode == XFM_LOW_FREQ);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.xflag <= 1'b1;
            st_q.gflag <= 1'b1;
            st_q.sel   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    xfm_clk_switch u_sw (
        .rst_n   (rst_n),
        .sel_b   (st_q.sel),
        .clk_a   (xtal_in),
        .kill_a  (osc_dead),
        .clk_b   (ref_clk),
        .a_en    (x_en),
        .b_en    (b_en),
        .clk_out (aux_clk)
    );

    assign xfault     = st_q.xflag;
    assign gfault     = st_q.gflag;
    assign aux_backup = st_q.sel;

    logic unused_lvl;
    assign unused_lvl = xtal_lvl;
endmodule

// File: rtl/xfm_checker.sv
module xfm_checker (
    input logic clk,
    input logic rst_n,
    input logic xfault,
    input logic gfault,
    input logic clr_gfault,
    input logic osc_dead,
    input logic run_ok,
    input logic x_en,
    input logic b_en
);
    // R2
    dead_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        osc_dead |=> xfault);

    // R7
    xf_implies_gf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfault |-> gfault);

    // R8
    gf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gfault && !clr_gfault) |=> gfault);

    // R3
    clr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfault && !run_ok) |=> xfault);

    // R10
    one_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(x_en && b_en));
endmodule

bind xtal_fault_mon xfm_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfault     (xfault),
    .gfault     (gfault),
    .clr_gfault (clr_gfault),
    .osc_dead   (osc_dead),
    .run_ok     (run_ok),
    .x_en       (x_en),
    .b_en       (b_en)
);

// File: tb/xtal_fault_mon_test.sv
module xtal_fault_mon_test;
    localparam int XHALF = 4;   // crystal half period in clk cycles
    localparam int RHALF = 3;   // reference half period in clk cycles

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xtal_in = 1'b0;
    logic ref_clk = 1'b0;
    logic hf_mode = 1'b0;
    logic clr_xfault = 1'b0;
    logic clr_gfault = 1'b0;
    logic xrun = 1'b0;
    logic xfault, gfault, aux_backup, aux_clk;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    time last_edge = 0;
    time min_w = 64'd1000000;

    always #4 clk = ~clk;

    xtal_fault_mon #(.TIMEOUT_CYC(40), .LF_TICKS(64), .HF_TICKS(16)) uut (
        .clk(clk), .rst_n(rst_n), .xtal_in(xtal_in), .ref_clk(ref_clk),
        .hf_mode(hf_mode), .clr_xfault(clr_xfault), .clr_gfault(clr_gfault),
        .xfault(xfault), .gfault(gfault), .aux_backup(aux_backup),
        .aux_clk(aux_clk)
    );

    initial forever begin
        repeat (XHALF) @(posedge clk);
        xtal_in <= xrun ? ~xtal_in : 1'b0;
    end

    initial forever begin
        repeat (RHALF) @(posedge clk);
        ref_clk <= ~ref_clk;
    end

    always @(aux_clk) begin
        if (rst_n && last_edge != 0 && ($time - last_edge) < min_w)
            min_w = $time - last_edge;
        if (rst_n) last_edge = $time;
    end

    task automatic check(string req, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clr_x();
        @(negedge clk) clr_xfault = 1'b1;
        @(negedge clk) clr_xfault = 1'b0;
    endtask

    task automatic pulse_clr_g();
        @(negedge clk) clr_gfault = 1'b1;
        @(negedge clk) clr_gfault = 1'b0;
    endtask

    task automatic aux_follows(string req, bit want_ref);
        for (int i = 0; i < 10; i++) begin
            wait_cyc(1);
            check(req, aux_clk, want_ref ? ref_clk : xtal_in);
        end
    endtask

    task automatic t_reset();
        wait_cyc(1);
        check("R1 xfault", xfault, 1'b1);
        check("R1 gfault", gfault, 1'b1);
        check("R1 aux_backup", aux_backup, 1'b1);
    endtask

    task automatic t_early_clear();
        xrun = 1'b1;
        wait_cyc(160);
        pulse_clr_x();
        check("R3 clear below LF threshold", xfault, 1'b1);
        pulse_clr_g();
        check("R8 gclear while xfault set", gfault, 1'b1);
    endtask

    task automatic t_late_clear();
        wait_cyc(500);
        pulse_clr_x();
        check("R4 clear after LF threshold", xfault, 1'b0);
        wait_cyc(5);
        check("R7 gfault kept by hardware", gfault, 1'b1);
        check("R9 backup while gfault", aux_backup, 1'b1);
        aux_follows("R9 aux on ref", 1'b1);
    endtask

    task automatic t_switch();
        pulse_clr_g();
        check("R8 gclear accepted", gfault, 1'b0);
        check("R9 backup released", aux_backup, 1'b0);
        wait_cyc(80);
        aux_follows("R9 aux on crystal", 1'b0);
    endtask

    task automatic t_stop();
        xrun = 1'b0;
        wait_cyc(25);
        check("R2 no fault inside window", xfault, 1'b0);
        wait_cyc(40);
        check("R2 fault after window", xfault, 1'b1);
        check("R7 gfault follows xfault", gfault, 1'b1);
        check("R9 backup on fault", aux_backup, 1'b1);
        wait_cyc(40);
        aux_follows("R9 aux on ref after stop", 1'b1);
    endtask

    task automatic t_interrupted();
        xrun = 1'b1;
        wait_cyc(320);
        xrun = 1'b0;
        wait_cyc(80);
        check("R6 dead interval sets flag", xfault, 1'b1);
        xrun = 1'b1;
        wait_cyc(320);
        pulse_clr_x();
        check("R6 count restarted", xfault, 1'b1);
        wait_cyc(240);
        pulse_clr_x();
        check("R6 clear after full run", xfault, 1'b0);
        pulse_clr_g();
        check("R8 gclear accepted again", gfault, 1'b0);
    endtask

    task automatic t_high_freq();
        hf_mode = 1'b1;
        xrun = 1'b0;
        wait_cyc(80);
        check("R2 fault in HF mode", xfault, 1'b1);
        check("R9 no backup in HF mode", aux_backup, 1'b0);
        xrun = 1'b1;
        wait_cyc(64);
        pulse_clr_x();
        check("R5 clear below HF threshold", xfault, 1'b1);
        wait_cyc(120);
        pulse_clr_x();
        check("R5 clear after HF threshold", xfault, 1'b0);
    endtask

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        t_reset();
        t_early_clear();
        t_late_clear();
        t_switch();
        t_stop();
        t_interrupted();
        t_high_freq();
        // R10: shortest pulse on aux_clk must not undercut the reference half period
        check("R10 no runt pulse", min_w >= 64'd24, 1'b1);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule